// File: doc/BRIEF.md
# Binomial Image Pyramid Decimator

This block turns one level of a luminance image pyramid into the next, coarser level. Pixels arrive as a raster stream of 8-bit values with a valid/ready handshake. A flag marks the first pixel of a frame and another marks the last pixel of each line. Each pixel is smoothed with a 5×5 binomial kernel, and the block keeps only the pixels that sit at even column and even row. The result is an integer image of half the width and half the height, sent out on a stream of the same form.

The kernel is separable. Four line stores hold the earlier rows. A vertical pass sums each column of five pixels with weights 1, 4, 6, 4, 1. A horizontal pass applies the same weights across five of those column sums. Pixels that fall outside the image are replaced by the nearest edge pixel. The output stream carries its own frame-start and end-of-line flags for the decimated frame. Several levels are built by chaining instances, with each output stream feeding the input of the next instance, which is set to half the dimensions.

The input image width `IMG_W` and height `IMG_H` are parameters. Both must be even and at least 4. `IMG_W` is also the depth of the line stores, and its intended maximum is 640.

Top module: `pyr_down`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `out_valid` is low and `in_ready` is high.
- R2: Each output pixel at (ox, oy) equals (S + 128) >> 8, where S = Σ k[i]·k[j]·I(2·ox+j−2, 2·oy+i−2) for i, j = 0..4 and k = {1,4,6,4,1}. The result is an integer in 0..255.
- R3: For each input frame of IMG_W × IMG_H pixels, exactly (IMG_W/2) × (IMG_H/2) outputs are produced, in raster order. No output is produced without input.
- R4: A coordinate outside the image is clamped to the nearest valid column and row before its pixel is read. This applies to all four edges.
- R5: `out_sof` is high only on the output pixel (0,0) of a frame. `out_eol` is high only on the output pixel at column IMG_W/2−1, and on every such pixel.
- R6: While `out_valid` is high and `out_ready` is low, the output pixel and its flags hold steady, and nothing is lost. `in_ready` is high whenever `out_valid` is low.
- R7: A uniform image gives the same value at every output, including the full-scale value 255, with no overflow.
- R8: The output stream of one instance can feed, unchanged, the input of a second instance sized at half the width and half the height. The second instance then produces the next pyramid level according to R2.
- R9: Idle cycles with `in_valid` low, placed anywhere in the input stream, do not change the output values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block accepts the input pixel this cycle |
| in_pix | input | 8 | Input luminance |
| in_sof | input | 1 | Input pixel is (0,0) of a frame |
| in_eol | input | 1 | Input pixel is the last of its line |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_pix | output | 8 | Decimated, filtered luminance |
| out_sof | output | 1 | Output pixel is (0,0) of the decimated frame |
| out_eol | output | 1 | Output pixel is the last of its decimated line |

## Verification
Each input pattern targets one behaviour. Uniform frames at 200 and at 255 show whether the normalisation and rounding are exact and whether the full-scale sum fits. Single bright pixels in the top-left and bottom-right corners can only match the reference when the edge clamping is correct on all four sides. A ramp, a checkerboard and two pseudo-random frames expose errors in tap order, weights or line-store order, because no single mistake cancels on them. The last frames run with output stalls and input gaps, and a second instance in cascade checks the next level against a reference built from the first level's expected output.

// File: rtl/pyr_pkg.sv
package pyr_pkg;

  localparam int PIX_W  = 8;
  localparam int VSUM_W = 12;  // 16 * 255 fits
  localparam int HSUM_W = 16;  // 256 * 255 fits
  localparam int ACC_W  = HSUM_W + 4;
  localparam int TAPS   = 4;   // history depth of both passes

  typedef enum logic [1:0] {
    EDGE_MID  = 2'd0,
    EDGE_HEAD = 2'd1,
    EDGE_TAIL = 2'd2
  } edge_e;

  // weights 1 4 6 4 1, multiplies as shifts
  function automatic logic [ACC_W-1:0] binom5(
    input logic [HSUM_W-1:0] a, input logic [HSUM_W-1:0] b,
    input logic [HSUM_W-1:0] c, input logic [HSUM_W-1:0] d,
    input logic [HSUM_W-1:0] e);
    logic [ACC_W-1:0] xa, xb, xc, xd, xe;
    xa = ACC_W'(a); xb = ACC_W'(b); xc = ACC_W'(c);
    xd = ACC_W'(d); xe = ACC_W'(e);
    return xa + (xb << 2) + (xc << 2) + (xc << 1) + (xd << 2) + xe;
  endfunction

  // cur is the newest sample, h0 one older, h3 four older; centre is h1
  function automatic logic [ACC_W-1:0] window5(
    input edge_e mode, input logic [HSUM_W-1:0] cur,
    input logic [HSUM_W-1:0] h0, input logic [HSUM_W-1:0] h1,
    input logic [HSUM_W-1:0] h2, input logic [HSUM_W-1:0] h3);
    case (mode)
      EDGE_HEAD: return binom5(h1, h1, h1, h0, cur);
      EDGE_TAIL: return binom5(h2, h1, h0, cur, cur);
      default:   return binom5(h3, h2, h1, h0, cur);
    endcase
  endfunction

  // a window completes at every even position from 2 on, and at the edge
  function automatic logic tap_emit(input int unsigned pos, input logic last);
    return last || (pos >= 2 && pos[0] == 1'b0);
  endfunction

  function automatic edge_e tap_mode(input int unsigned pos, input logic last);
    if (last) return EDGE_TAIL;
    if (pos == 2) return EDGE_HEAD;
    return EDGE_MID;
  endfunction

  function automatic logic [PIX_W-1:0] norm256(input logic [ACC_W-1:0] s);
    logic [ACC_W-1:0] t;
    t = s + ACC_W'(128);
    return PIX_W'(t >> 8);
  endfunction

endpackage

// File: rtl/pyr_linebuf.sv
module pyr_linebuf
  import pyr_pkg::*;
#(
  parameter int DEPTH = 640,
  parameter int ROWS  = TAPS,
  localparam int CW   = $clog2(DEPTH)
) (
  input  logic                           clk,
  input  logic                           wr_en,
  input  logic [CW-1:0]                  col,
  input  logic [PIX_W-1:0]               din,
  output logic [ROWS-1:0][PIX_W-1:0]     taps
);

  // row k holds the line k+1 above the current one; a write shifts the column
  for (genvar k = 0; k < ROWS; k++) begin : g_row
    logic [PIX_W-1:0] mem [DEPTH];
    logic [PIX_W-1:0] wdata;
    if (k == 0) begin : g_head
      assign wdata = din;
    end else begin : g_chain
      assign wdata = taps[k-1];
    end
    always_ff @(posedge clk) begin
      if (wr_en) mem[col] <= wdata;
    end
    assign taps[k] = mem[col];
  end

endmodule

// File: rtl/pyr_vpass.sv
module pyr_vpass
  import pyr_pkg::*;
#(
  parameter int IMG_H = 480,
  parameter int CW    = 10,
  parameter int RW    = 9
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          adv,
  input  logic                          in_fire,
  input  logic [PIX_W-1:0]              cur_pix,
  input  logic [TAPS-1:0][PIX_W-1:0]    rows,
  input  logic [CW-1:0]                 col,
  input  logic [RW-1:0]                 row,
  input  logic                          eol,
  output logic                          s1_vld,
  output logic [VSUM_W-1:0]             s1_vsum,
  output logic [CW-1:0]                 s1_col,
  output logic                          s1_eol,
  output logic                          s1_top
);

  logic        row_last;
  logic        row_emit;
  edge_e       row_mode;
  logic [ACC_W-1:0] col_sum;

  assign row_last = (32'(row) == IMG_H - 1);
  assign row_emit = tap_emit(32'(row), row_last);
  assign row_mode = tap_mode(32'(row), row_last);
  assign col_sum  = window5(row_mode, HSUM_W'(cur_pix),
                            HSUM_W'(rows[0]), HSUM_W'(rows[1]),
                            HSUM_W'(rows[2]), HSUM_W'(rows[3]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_vsum <= '0;
      s1_col  <= '0;
      s1_eol  <= 1'b0;
      s1_top  <= 1'b0;
    end else if (adv) begin
      s1_vld  <= in_fire && row_emit;
      s1_vsum <= VSUM_W'(col_sum);
      s1_col  <= col;
      s1_eol  <= eol;
      s1_top  <= (row_mode == EDGE_HEAD);
    end
  end

endmodule

// File: rtl/pyr_hpass.sv
module pyr_hpass
  import pyr_pkg::*;
#(
  parameter int CW = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv,
  input  logic               s1_vld,
  input  logic [VSUM_W-1:0]  s1_vsum,
  input  logic [CW-1:0]      s1_col,
  input  logic               s1_eol,
  input  logic               s1_top,
  output logic               out_valid,
  output logic [PIX_W-1:0]   out_pix,
  output logic               out_sof,
  output logic               out_eol
);

  logic [TAPS-1:0][VSUM_W-1:0] hwin;  // hwin[0] newest
  logic        col_emit;
  edge_e       col_mode;
  logic [ACC_W-1:0] row_sum;

  assign col_emit = tap_emit(32'(s1_col), s1_eol);
  assign col_mode = tap_mode(32'(s1_col), s1_eol);
  assign row_sum  = window5(col_mode, HSUM_W'(s1_vsum),
                            HSUM_W'(hwin[0]), HSUM_W'(hwin[1]),
                            HSUM_W'(hwin[2]), HSUM_W'(hwin[3]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hwin <= '0;
    end else if (adv && s1_vld) begin
      hwin <= {hwin[TAPS-2:0], s1_vsum};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
      out_sof   <= 1'b0;
      out_eol   <= 1'b0;
    end else if (adv) begin
      out_valid <= s1_vld && col_emit;
      if (s1_vld && col_emit) begin
        out_pix <= norm256(row_sum);
        out_sof <= s1_top && (col_mode == EDGE_HEAD);
        out_eol <= s1_eol;
      end
    end
  end

endmodule

// File: rtl/pyr_down.sv
module pyr_down
  import pyr_pkg::*;
#(
  parameter int IMG_W = 640,
  parameter int IMG_H = 480
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_pix,
  input  logic       in_sof,
  input  logic       in_eol,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_pix,
  output logic       out_sof,
  output logic       out_eol
);

  localparam int CW = $clog2(IMG_W);
  localparam int RW = $clog2(IMG_H);

  // named events, also used by the bound checker
  logic adv;
  logic in_fire;
  logic out_fire;

  logic [CW-1:0] col_q, cur_col;
  logic [RW-1:0] row_q, cur_row;
  logic [TAPS-1:0][PIX_W-1:0] rows;

  logic              s1_vld, s1_eol, s1_top;
  logic [VSUM_W-1:0] s1_vsum;
  logic [CW-1:0]     s1_col;

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;
  assign in_fire  = in_valid && in_ready;
  assign out_fire = out_valid && out_ready;

  assign cur_col = in_sof ? '0 : col_q;
  assign cur_row = in_sof ? '0 : row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
    end else if (in_fire) begin
      if (in_eol) begin
        col_q <= '0;
        row_q <= cur_row + RW'(1);
      end else begin
        col_q <= cur_col + CW'(1);
        row_q <= cur_row;
      end
    end
  end

  pyr_linebuf #(.DEPTH(IMG_W), .ROWS(TAPS)) u_lines (
    .clk   (clk),
    .wr_en (in_fire),
    .col   (cur_col),
    .din   (in_pix),
    .taps  (rows)
  );

  pyr_vpass #(.IMG_H(IMG_H), .CW(CW), .RW(RW)) u_vpass (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (adv),
    .in_fire (in_fire),
    .cur_pix (in_pix),
    .rows    (rows),
    .col     (cur_col),
    .row     (cur_row),
    .eol     (in_eol),
    .s1_vld  (s1_vld),
    .s1_vsum (s1_vsum),
    .s1_col  (s1_col),
    .s1_eol  (s1_eol),
    .s1_top  (s1_top)
  );

  pyr_hpass #(.CW(CW)) u_hpass (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (adv),
    .s1_vld    (s1_vld),
    .s1_vsum   (s1_vsum),
    .s1_col    (s1_col),
    .s1_eol    (s1_eol),
    .s1_top    (s1_top),
    .out_valid (out_valid),
    .out_pix   (out_pix),
    .out_sof   (out_sof),
    .out_eol   (out_eol)
  );

endmodule

// File: rtl/pyr_down_chk.sv
module pyr_down_chk #(
  parameter int IMG_W = 640
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic       out_fire,
  input logic [7:0] out_pix,
  input logic       out_sof,
  input logic       out_eol
);

  localparam int OUT_W = IMG_W / 2;

  logic [15:0] line_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_cnt <= '0;
    else if (out_fire) line_cnt <= out_eol ? '0 : line_cnt + 16'd1;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!out_valid && in_ready));

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_pix) && $stable(out_sof) && $stable(out_eol)));

  // R6
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R5
  eol_position_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_eol) |-> (line_cnt == 16'(OUT_W - 1)));

  // R5
  sof_position_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sof) |-> (line_cnt == 16'd0));

endmodule

bind pyr_down pyr_down_chk #(.IMG_W(IMG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_fire  (out_fire),
  .out_pix   (out_pix),
  .out_sof   (out_sof),
  .out_eol   (out_eol)
);

// File: tb/pyr_down_bench.sv
module pyr_down_bench;

  localparam int W0 = 8, H0 = 8, W1 = 4, H1 = 4;

  typedef struct {
    int pix;
    bit sof;
    bit eol;
    int tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0;
  logic [7:0] in_pix = 8'd0;
  logic       in_ready;
  logic       mid_valid, mid_ready, mid_sof, mid_eol;
  logic [7:0] mid_pix;
  logic       out_valid, out_sof, out_eol;
  logic       out_ready = 1'b1;
  logic [7:0] out_pix;

  pyr_down #(.IMG_W(W0), .IMG_H(H0)) u_pyr_down (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix),
    .in_sof(in_sof), .in_eol(in_eol),
    .out_valid(mid_valid), .out_ready(mid_ready), .out_pix(mid_pix),
    .out_sof(mid_sof), .out_eol(mid_eol)
  );

  pyr_down #(.IMG_W(W1), .IMG_H(H1)) u_pyr_down_l2 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(mid_valid), .in_ready(mid_ready), .in_pix(mid_pix),
    .in_sof(mid_sof), .in_eol(mid_eol),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix),
    .out_sof(out_sof), .out_eol(out_eol)
  );

  int checks = 0;
  int fails = 0;
  bit stall_on = 1'b0;
  bit gap_on = 1'b0;
  bit finished = 1'b0;
  item_t q1[$];
  item_t q2[$];
  int kern[5] = '{1, 4, 6, 4, 1};
  int lvl0[8][8];
  int lvl1[8][8];

  function automatic string req_tag(int n);
    case (n)
      2: return "R2";
      4: return "R4";
      6: return "R6";
      7: return "R7";
      8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  function automatic int pat_val(int pat, int x, int y);
    case (pat)
      0: return 200;
      1: return 255;
      2: return (x == 0 && y == 0) ? 255 : 0;
      3: return (x == 7 && y == 7) ? 255 : 0;
      4: return x * 32 + y * 3;
      5: return ((x + y) % 2 == 1) ? 255 : 0;
      6: return (x * 37 + y * 91 + x * y * 13 + 11) % 256;
      default: return (x * 53 + y * 29 + x * x * 7 + y * y * 5 + 3) % 256;
    endcase
  endfunction

  // direct 2D kernel with clamped coordinates (R2, R4)
  function automatic int ref_pix(bit second, int w, int h, int ox, int oy);
    int s = 0;
    for (int i = 0; i < 5; i++) begin
      for (int j = 0; j < 5; j++) begin
        int yy = 2 * oy + i - 2;
        int xx = 2 * ox + j - 2;
        int v;
        if (yy < 0) yy = 0;
        if (yy > h - 1) yy = h - 1;
        if (xx < 0) xx = 0;
        if (xx > w - 1) xx = w - 1;
        v = second ? lvl1[yy][xx] : lvl0[yy][xx];
        s += kern[i] * kern[j] * v;
      end
    end
    return (s + 128) / 256;
  endfunction

  task automatic send_pix(int v, bit s, bit e);
    in_valid = 1'b1;
    in_pix = 8'(v);
    in_sof = s;
    in_eol = e;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic run_frame(int pat, int tag, bit st, bit gp);
    item_t it;
    stall_on = st;
    gap_on = gp;
    for (int y = 0; y < H0; y++)
      for (int x = 0; x < W0; x++) lvl0[y][x] = pat_val(pat, x, y);
    for (int oy = 0; oy < H0 / 2; oy++)
      for (int ox = 0; ox < W0 / 2; ox++) begin
        lvl1[oy][ox] = ref_pix(1'b0, W0, H0, ox, oy);
        it.pix = lvl1[oy][ox];
        it.sof = (ox == 0 && oy == 0);
        it.eol = (ox == W0 / 2 - 1);
        it.tag = tag;
        q1.push_back(it);
      end
    // R8: next level from the expected first level
    for (int oy = 0; oy < H1 / 2; oy++)
      for (int ox = 0; ox < W1 / 2; ox++) begin
        it.pix = ref_pix(1'b1, W1, H1, ox, oy);
        it.sof = (ox == 0 && oy == 0);
        it.eol = (ox == W1 / 2 - 1);
        it.tag = 8;
        q2.push_back(it);
      end
    for (int y = 0; y < H0; y++)
      for (int x = 0; x < W0; x++) begin
        if (gap_on && ((x + 2 * y) % 3 == 0)) begin
          @(posedge clk);
          #1;
        end
        send_pix(lvl0[y][x], (x == 0 && y == 0), (x == W0 - 1));
      end
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      out_ready = stall_on ? (cyc % 3 != 0) : 1'b1;
    end
  end

  bit hold_prev = 1'b0;
  int prev_pix = 0;
  always @(negedge clk) begin
    item_t it;
    if (rst_n && !finished) begin
      if (mid_valid && mid_ready) begin
        if (q1.size() == 0) check(1'b0, "R3", "extra level-1 output", int'(mid_pix), -1);
        else begin
          it = q1.pop_front();
          check(int'(mid_pix) == it.pix, req_tag(it.tag), "level-1 pixel", int'(mid_pix), it.pix);
          check(mid_sof == it.sof && mid_eol == it.eol, "R5", "level-1 sof/eol",
                int'({mid_sof, mid_eol}), int'({it.sof, it.eol}));
        end
      end
      if (out_valid && out_ready) begin
        if (q2.size() == 0) check(1'b0, "R3", "extra level-2 output", int'(out_pix), -1);
        else begin
          it = q2.pop_front();
          check(int'(out_pix) == it.pix, req_tag(it.tag), "level-2 pixel", int'(out_pix), it.pix);
          check(out_sof == it.sof && out_eol == it.eol, "R5", "level-2 sof/eol",
                int'({out_sof, out_eol}), int'({it.sof, it.eol}));
        end
      end
      // R6: stalled output holds its value
      if (hold_prev)
        check(out_valid && int'(out_pix) == prev_pix, "R6", "held output pixel",
              int'(out_pix), prev_pix);
      hold_prev = out_valid && !out_ready;
      prev_pix = int'(out_pix);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      check(1'b0, "R3", "watchdog expired", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 during reset
    check(!mid_valid && !out_valid, "R1", "valid in reset", int'(mid_valid), 0);
    check(in_ready == 1'b1, "R1", "ready in reset", int'(in_ready), 1);
    @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!mid_valid && !out_valid, "R1", "valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1", "ready after reset", int'(in_ready), 1);

    run_frame(0, 7, 1'b0, 1'b0);  // R7 uniform 200
    run_frame(1, 7, 1'b0, 1'b0);  // R7 full scale
    run_frame(2, 4, 1'b0, 1'b0);  // R4 top-left impulse
    run_frame(3, 4, 1'b0, 1'b0);  // R4 bottom-right impulse
    run_frame(4, 2, 1'b0, 1'b0);  // R2 ramp
    run_frame(5, 6, 1'b1, 1'b0);  // R6 checkerboard under stalls
    run_frame(6, 9, 1'b0, 1'b1);  // R9 input gaps
    run_frame(7, 6, 1'b1, 1'b1);  // R6 stalls and gaps together

    stall_on = 1'b0;
    gap_on = 1'b0;
    repeat (80) @(posedge clk);
    @(negedge clk);
    // R3 every expected output arrived
    check(q1.size() == 0, "R3", "level-1 outputs missing", q1.size(), 0);
    check(q2.size() == 0, "R3", "level-2 outputs missing", q2.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      summary();
      $finish;
    end
  end

endmodule